// File: doc/BRIEF.md
# Rectangle Readback Packer

This block returns a rectangular window of a 16-bit-per-pixel frame memory to a processor, one 32-bit word per read. A transfer is armed by giving an origin (column and row) and a size (width and height in pixels). Each read request fetches up to two pixels from the memory and packs them into one word. Pixels are taken in raster order: left to right along a line of the window, then down to the next line. Memory coordinates wrap around both memory edges.

When the last pixel of the window has been fetched, the transfer ends at once and the block returns to idle. If the window holds an odd number of pixels, the unused upper half of the final word is zero. Every word handed out is also held in an output latch. A read made while no transfer is running returns that held word again and does not access the memory.

The frame memory itself sits outside the block. It is a synchronous RAM with one read port and one cycle of read latency. Decoding the command that arms a transfer is done elsewhere.

Top module: `rect_readback`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` is 0.
- R2: While `busy` is 0, a read request is acknowledged without asserting `mem_rd_en`, and it returns the held word unchanged.
- R3: A returned word carries the first fetched pixel in bits 15:0 and the second fetched pixel in bits 31:16.
- R4: The pixel at window column c and window row r is read from memory address ((y+r) mod MEM_H) * MEM_W + ((x+c) mod MEM_W).
- R5: The column advances once per pixel. When it reaches the width, it returns to 0 and the row advances, so a single word may hold pixels from two lines of the window.
- R6: When the final pixel of the window lands in the low half of a word, the transfer ends with that word, and bits 31:16 of that word are zero.
- R7: Every word that is acknowledged stays on `rd_data` until the next acknowledge. `rd_data` changes only together with `rd_ack`.
- R8: `busy` rises on the edge after a start is accepted. It stays high for the whole transfer and falls on the same edge that presents the acknowledge of the final word.
- R9: A `start` while `busy` is 1 is ignored, and the running transfer continues unchanged.
- R10: A `start` with a width of 0 or a height of 0 is ignored: `busy` stays 0.
- R11: `rd_ack` is a one-cycle pulse. Its latency, counted in cycles from the cycle in which the request is raised, is as follows:
  - an idle read takes 1 cycle and no memory read;
  - a two-pixel word takes 3 cycles and two memory reads;
  - an odd final word takes 2 cycles and one memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arm a transfer with the values on the start_* inputs |
| start_x | input | $clog2(MEM_W) | Window origin column |
| start_y | input | $clog2(MEM_H) | Window origin row |
| start_w | input | $clog2(MEM_W)+1 | Window width in pixels |
| start_h | input | $clog2(MEM_H)+1 | Window height in lines |
| rd_req | input | 1 | Read request, held high until rd_ack is seen |
| rd_ack | output | 1 | One-cycle acknowledge; rd_data is valid with it |
| rd_data | output | 32 | Packed word, also the held latch value |
| busy | output | 1 | High while a transfer is running |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | $clog2(MEM_W*MEM_H) | Memory pixel address |
| mem_rd_data | input | 16 | Memory read data, valid one cycle after the strobe |

## Verification
The bench builds the block with an 8 by 4 pixel memory of 32 words, filled with distinct values that are computed from the address. With a memory this small, windows of a few pixels can cross the right edge and the bottom edge in the same transfer. Each wrapped pixel shows up in a known half of a known word. Odd widths are combined with several lines, so that words span two lines and the transfer can end on a low half. A start is issued during a running transfer, and starts with zero width or zero height are issued while idle.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int PIX_W  = 16;
    localparam int WORD_W = 2 * PIX_W;

    typedef enum logic [1:0] {
        ST_IDLE,   // no transfer; reads return the held word
        ST_FETCH,  // waiting for a request, then issue the low pixel
        ST_LOW,    // low pixel arrives, high pixel issued
        ST_HIGH    // high pixel arrives, word complete
    } rr_state_e;

endpackage

// File: rtl/rr_cursor.sv
module rr_cursor #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic [XW:0] col,
    input  logic [XW:0] w,
    input  logic [YW:0] row,
    input  logic [YW:0] h,
    output logic [XW:0] col_nx,
    output logic [YW:0] row_nx,
    output logic        last
);

    always_comb begin
        col_nx = col + (XW+1)'(1);
        row_nx = row;
        last   = 1'b0;
        if (col_nx == w) begin
            col_nx = '0;
            row_nx = row + (YW+1)'(1);
            last   = (row_nx == h);
        end
    end

endmodule

// File: rtl/rr_addr.sv
module rr_addr #(
    parameter int MEM_W = 1024,
    parameter int MEM_H = 512,
    parameter int XW    = $clog2(MEM_W),
    parameter int YW    = $clog2(MEM_H),
    parameter int AW    = $clog2(MEM_W * MEM_H)
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW:0]   col,
    input  logic [YW:0]   row,
    output logic [AW-1:0] addr
);

    localparam bit X_POW2 = (MEM_W == (1 << XW));
    localparam bit Y_POW2 = (MEM_H == (1 << YW));

    logic [XW+1:0] xs;
    logic [YW+1:0] ys;
    logic [XW-1:0] xw;
    logic [YW-1:0] yw;

    assign xs = (XW+2)'(x) + (XW+2)'(col);
    assign ys = (YW+2)'(y) + (YW+2)'(row);

    generate
        if (X_POW2) begin : g_x_mask
            assign xw = XW'(xs & (XW+2)'(MEM_W - 1));
        end else begin : g_x_mod
            assign xw = XW'(xs % (XW+2)'(MEM_W));
        end
        if (Y_POW2) begin : g_y_mask
            assign yw = YW'(ys & (YW+2)'(MEM_H - 1));
        end else begin : g_y_mod
            assign yw = YW'(ys % (YW+2)'(MEM_H));
        end
    endgenerate

    assign addr = AW'(yw) * AW'(MEM_W) + AW'(xw);

endmodule

// File: rtl/rect_readback.sv
module rect_readback #(
    parameter int MEM_W = 1024,
    parameter int MEM_H = 512
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [$clog2(MEM_W)-1:0]           start_x,
    input  logic [$clog2(MEM_H)-1:0]           start_y,
    input  logic [$clog2(MEM_W):0]             start_w,
    input  logic [$clog2(MEM_H):0]             start_h,
    input  logic                               rd_req,
    output logic                               rd_ack,
    output logic [31:0]                        rd_data,
    output logic                               busy,
    output logic                               mem_rd_en,
    output logic [$clog2(MEM_W*MEM_H)-1:0]     mem_addr,
    input  logic [15:0]                        mem_rd_data
);
    import rr_pkg::*;

    localparam int XW = $clog2(MEM_W);
    localparam int YW = $clog2(MEM_H);
    localparam int AW = $clog2(MEM_W * MEM_H);

    typedef struct packed {
        rr_state_e          st;
        logic [XW-1:0]      x;
        logic [YW-1:0]      y;
        logic [XW:0]        w;
        logic [YW:0]        h;
        logic [XW:0]        col;
        logic [YW:0]        row;
        logic               fin;    // last issued pixel closes the window
        logic [PIX_W-1:0]   lo;
        logic [WORD_W-1:0]  latch;
        logic               ack;
    } regs_t;

    regs_t q, d;

    logic [XW:0] col_nx;
    logic [YW:0] row_nx;
    logic        cur_last;
    logic        req_new;

    rr_cursor #(.XW(XW), .YW(YW)) cursor_i (
        .col    (q.col),
        .w      (q.w),
        .row    (q.row),
        .h      (q.h),
        .col_nx (col_nx),
        .row_nx (row_nx),
        .last   (cur_last)
    );

    rr_addr #(.MEM_W(MEM_W), .MEM_H(MEM_H), .XW(XW), .YW(YW), .AW(AW)) addr_i (
        .x    (q.x),
        .y    (q.y),
        .col  (q.col),
        .row  (q.row),
        .addr (mem_addr)
    );

    assign req_new = rd_req && !q.ack;

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        mem_rd_en = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_new) begin
                    d.ack = 1'b1;
                end
                if (start && (start_w != '0) && (start_h != '0)) begin
                    d.x   = start_x;
                    d.y   = start_y;
                    d.w   = start_w;
                    d.h   = start_h;
                    d.col = '0;
                    d.row = '0;
                    d.fin = 1'b0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (req_new) begin
                    mem_rd_en = 1'b1;
                    d.col     = col_nx;
                    d.row     = row_nx;
                    d.fin     = cur_last;
                    d.st      = ST_LOW;
                end
            end
            ST_LOW: begin
                d.lo = mem_rd_data;
                if (q.fin) begin
                    d.latch = {{PIX_W{1'b0}}, mem_rd_data};
                    d.ack   = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    mem_rd_en = 1'b1;
                    d.col     = col_nx;
                    d.row     = row_nx;
                    d.fin     = cur_last;
                    d.st      = ST_HIGH;
                end
            end
            ST_HIGH: begin
                d.latch = {mem_rd_data, q.lo};
                d.ack   = 1'b1;
                d.st    = q.fin ? ST_IDLE : ST_FETCH;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_ack  = q.ack;
    assign rd_data = q.latch;
    assign busy    = (q.st != ST_IDLE);

endmodule

// File: rtl/rect_readback_chk.sv
module rect_readback_chk #(
    parameter int MEM_W = 1024,
    parameter int MEM_H = 512
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           rd_ack,
    input logic [31:0]                    rd_data,
    input logic                           busy,
    input logic                           mem_rd_en,
    input logic [$clog2(MEM_W*MEM_H)-1:0] mem_addr
);

    assert_idle_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en);

    assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (int'(mem_addr) < MEM_W * MEM_H));

    assert_data_moves_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> rd_ack);

    assert_idle_data_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(rd_data));

    assert_busy_falls_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rd_ack);

    assert_ack_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);

endmodule

bind rect_readback rect_readback_chk #(.MEM_W(MEM_W), .MEM_H(MEM_H)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr)
);

// File: tb/rect_readback_tb_top.sv
module rect_readback_tb_top;

    localparam int MW = 8;
    localparam int MH = 4;
    localparam int XW = 3;
    localparam int YW = 2;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [XW-1:0] start_x = '0;
    logic [YW-1:0] start_y = '0;
    logic [XW:0]   start_w = '0;
    logic [YW:0]   start_h = '0;
    logic          rd_req = 1'b0;
    logic          rd_ack;
    logic [31:0]   rd_data;
    logic          busy;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [15:0]   ram_q;
    logic [15:0]   ram [MW*MH];

    always #2 clk = ~clk;

    rect_readback #(.MEM_W(MW), .MEM_H(MH)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_x(start_x), .start_y(start_y),
        .start_w(start_w), .start_h(start_h), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(ram_q)
    );

    function automatic logic [15:0] pixval(int a);
        return 16'((a * 16'h0731) ^ 16'hC35A) | 16'h0100;
    endfunction

    initial begin
        for (int i = 0; i < MW*MH; i++) ram[i] = pixval(i);
    end

    always_ff @(posedge clk) if (mem_rd_en) ram_q <= ram[mem_addr];

    int n_checks = 0;
    int n_fail   = 0;
    int mem_reads = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always @(negedge clk) if (mem_rd_en) mem_reads++;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected ack", rd_data, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, "word", rd_data, e);
            end
        end
    end

    // reference model of the window cursor
    int m_x, m_y, m_w, m_h, m_col, m_row;
    bit m_act = 1'b0;
    logic [31:0] m_latch = '0;

    task automatic model_pix(output logic [15:0] p);
        p = pixval(((m_y + m_row) % MH) * MW + ((m_x + m_col) % MW));
        m_col++;
        if (m_col == m_w) begin
            m_col = 0;
            m_row++;
            if (m_row == m_h) m_act = 1'b0;
        end
    endtask

    task automatic do_start(int x, int y, int w, int h);
        @(negedge clk);
        start = 1'b1;
        start_x = XW'(x); start_y = YW'(y);
        start_w = (XW+1)'(w); start_h = (YW+1)'(h);
        @(negedge clk);
        start = 1'b0;
        if (!m_act && w != 0 && h != 0) begin
            m_x = x; m_y = y; m_w = w; m_h = h; m_col = 0; m_row = 0; m_act = 1'b1;
        end
    endtask

    task automatic read_word(string tag);
        logic [15:0] p0, p1;
        logic [31:0] e;
        int exp_lat, exp_rd, lat;
        if (!m_act) begin
            e = m_latch; exp_lat = 1; exp_rd = 0;
        end else begin
            model_pix(p0);
            if (!m_act) begin
                e = {16'h0, p0}; exp_lat = 2; exp_rd = 1;
            end else begin
                model_pix(p1);
                e = {p1, p0}; exp_lat = 3; exp_rd = 2;
            end
        end
        m_latch = e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        mem_reads = 0;
        rd_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ack && lat < 20);
        rd_req = 1'b0;
        check(lat == exp_lat, "R11", "ack latency", lat, exp_lat);
        check(mem_reads == exp_rd, (exp_rd == 0) ? "R2" : "R11", "memory reads", mem_reads, exp_rd);
        check(busy == m_act, "R8", "busy after word", busy, m_act);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(4 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(rd_data == 32'h0, "R1", "data after reset", rd_data, 0);
        read_word("R2");

        // plain window, two lines of four
        do_start(1, 0, 4, 2);
        check(busy == 1'b1, "R8", "busy after start", busy, 1);
        for (int i = 0; i < 4; i++) read_word("R3");
        read_word("R7");

        // window crossing right and bottom edges
        do_start(6, 3, 4, 2);
        for (int i = 0; i < 4; i++) read_word("R4");
        read_word("R7");

        // odd single line: final word has a zero upper half
        do_start(2, 1, 3, 1);
        read_word("R3");
        read_word("R6");
        read_word("R7");

        // odd width over three lines: words straddle lines, ends on low half
        do_start(5, 2, 3, 3);
        for (int i = 0; i < 4; i++) read_word("R5");
        read_word("R6");
        read_word("R7");

        // start while busy is ignored
        do_start(0, 0, 2, 1);
        do_start(4, 3, 4, 4);
        check(busy == 1'b1, "R9", "busy during ignored start", busy, 1);
        read_word("R9");
        check(busy == 1'b0, "R9", "busy after single word", busy, 0);
        read_word("R7");

        // zero-sized starts are ignored
        do_start(3, 1, 0, 2);
        check(busy == 1'b0, "R10", "busy after zero width", busy, 0);
        do_start(3, 1, 2, 0);
        check(busy == 1'b0, "R10", "busy after zero height", busy, 0);
        read_word("R10");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R11", "pending expected words", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule